// File: doc/BRIEF.md
# Byte-Memory DMA Word Packer

This block moves a run of words between an 8-bit external byte memory and a 24-bit internal memory. Reading from byte memory, it collects consecutive bytes and writes one assembled word per group into internal memory. Writing to byte memory, it reads each internal word once and sends it out as a sequence of bytes. A 2-bit format code sets how many bytes make a word and where they sit inside it. Bytes that make up one word are always ordered with the most significant one at the lowest byte address. Bits of the internal word that the format does not use are zero.

Software or a controlling block drives the configuration inputs and pulses `start`. The engine latches the configuration, runs the whole transfer with a programmable number of wait states on every external byte access, and then raises a sticky interrupt flag. The flag stays set until `irq_clr` is pulsed. The external address is the page number followed by a byte address. The byte address advances after every byte, and the internal address advances after every word.

Top module: `bytedma_packer`

## Requirements
- R1: Format code 2'b00 forms a 24-bit word from three consecutive bytes. The byte at the lowest address lands in bits 23:16 and the byte at the highest address in bits 7:0.
- R2: Format code 2'b01 forms a word from two consecutive bytes. The lower-address byte goes to bits 15:8, the next byte goes to bits 7:0, and bits 23:16 are zero.
- R3: Format code 2'b10 moves one byte per word into bits 15:8. Bits 23:16 and 7:0 are zero.
- R4: Format code 2'b11 moves one byte per word into bits 7:0. Bits 23:8 are zero.
- R5: Each external byte access holds its strobe (`ext_rd` or `ext_wr`) high for `cfg_wait`+1 cycles at one address, for any `cfg_wait` from 0 to 7. The two strobes are never high together.
- R6: `ext_addr` carries the page in its upper `PAGE_W` bits and the byte address in its lower `EADDR_W` bits. The byte address starts at `cfg_ext_addr` and increases by one per byte. The internal address starts at `cfg_int_addr` and increases by one per word.
- R7: With `cfg_dir`=1 (internal to byte memory), each word is read once through `int_re`, and its bytes are written most significant first under the same format rules. Format 2'b01 writes bits 15:8 then 7:0, format 2'b10 writes bits 15:8, and format 2'b11 writes bits 7:0.
- R8: `busy` rises in the cycle after an accepted `start` and stays high until the last access of the transfer completes. `irq` rises when `busy` falls. `irq` then stays high until `irq_clr` is pulsed. No strobe, `int_re` or `int_we` is active while `busy` is low.
- R9: Exactly `cfg_count` words are transferred. A `start` pulse that arrives while `busy` is high is ignored, and its configuration has no effect on the running transfer.
- R10: A `start` with `cfg_count`=0 performs no external or internal access, leaves `busy` low and sets `irq` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches a transfer with the current configuration |
| cfg_count | input | CNT_W | Number of words to move |
| cfg_dir | input | 1 | 0: byte memory to internal, 1: internal to byte memory |
| cfg_fmt | input | 2 | Word format code |
| cfg_page | input | PAGE_W | External page number |
| cfg_ext_addr | input | EADDR_W | First external byte address |
| cfg_int_addr | input | IADDR_W | First internal word address |
| cfg_wait | input | WAIT_W | Wait states added to every byte access |
| ext_addr | output | PAGE_W+EADDR_W | External byte address {page, byte address} |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_wdata | output | 8 | Byte written to byte memory |
| ext_rdata | input | 8 | Byte read from byte memory, sampled on the last strobe cycle |
| int_addr | output | IADDR_W | Internal word address |
| int_re | output | 1 | Internal read request, data expected one cycle later |
| int_rdata | input | 24 | Internal read data |
| int_we | output | 1 | Internal write enable |
| int_wdata | output | 24 | Assembled word written to internal memory |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky transfer-complete flag |
| irq_clr | input | 1 | Clears `irq` |

## Verification
A byte-index or accumulator fault shows up as a misplaced or non-zero byte on `int_wdata` in the write cycle of the first word it touches. Mis-sequencing the writes shows up on `ext_wdata` during the first word's strobes. A wait-counter fault changes the length of the very first strobe pulse, so the total count of strobe cycles differs from bytes times (`cfg_wait`+1). An address or word-count fault shows up only once the transfer ends, as a word or byte written one place off, or a sentinel just past the range being overwritten. The directed scenarios therefore compare every word of the destination and its neighbour after each run.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 24;

    typedef enum logic [1:0] {
        FMT_W24  = 2'b00,
        FMT_W16  = 2'b01,
        FMT_HI8  = 2'b10,
        FMT_LO8  = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_BYTE,
        ST_STORE
    } state_e;

    // index of the final byte of a word for a format
    function automatic logic [1:0] final_idx(fmt_e f);
        case (f)
            FMT_W24: final_idx = 2'd2;
            FMT_W16: final_idx = 2'd1;
            default: final_idx = 2'd0;
        endcase
    endfunction

    // shift history (newest byte in bits 7:0) to internal word
    function automatic logic [WORD_W-1:0] pack_word(fmt_e f, logic [WORD_W-1:0] hist);
        case (f)
            FMT_W24: pack_word = hist;
            FMT_W16: pack_word = {8'h00, hist[15:0]};
            FMT_HI8: pack_word = {8'h00, hist[7:0], 8'h00};
            default: pack_word = {16'h0000, hist[7:0]};
        endcase
    endfunction

    // internal word to a byte queue, first byte in bits 23:16
    function automatic logic [WORD_W-1:0] unpack_word(fmt_e f, logic [WORD_W-1:0] w);
        case (f)
            FMT_W24: unpack_word = w;
            FMT_W16: unpack_word = {w[15:0], 8'h00};
            FMT_HI8: unpack_word = {w[15:8], 16'h0000};
            default: unpack_word = {w[7:0], 16'h0000};
        endcase
    endfunction

endpackage

// File: rtl/bdp_wait_timer.sv
module bdp_wait_timer #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [WAIT_W-1:0] limit,
    output logic              done
);
    logic [WAIT_W-1:0] cnt_q;

    assign done = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || done) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bdp_assembler.sv
module bdp_assembler
    import bdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] byte_in,
    input  fmt_e              fmt,
    output logic [WORD_W-1:0] word_out
);
    logic [WORD_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[WORD_W-BYTE_W-1:0], byte_in};
    end

    assign word_out = pack_word(fmt, hist_q);
endmodule

// File: rtl/bdp_splitter.sv
module bdp_splitter
    import bdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  fmt_e              fmt,
    input  logic              shift_en,
    output logic [BYTE_W-1:0] byte_out
);
    logic [WORD_W-1:0] queue_q;

    always_ff @(posedge clk) begin
        if (rst)           queue_q <= '0;
        else if (load)     queue_q <= unpack_word(fmt, word_in);
        else if (shift_en) queue_q <= {queue_q[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
    end

    assign byte_out = queue_q[WORD_W-1 -: BYTE_W];
endmodule

// File: rtl/bytedma_packer.sv
module bytedma_packer
    import bdp_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter int IADDR_W = 14,
    parameter int EADDR_W = 14,
    parameter int PAGE_W  = 8,
    parameter int WAIT_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [CNT_W-1:0]          cfg_count,
    input  logic                      cfg_dir,
    input  logic [1:0]                cfg_fmt,
    input  logic [PAGE_W-1:0]         cfg_page,
    input  logic [EADDR_W-1:0]        cfg_ext_addr,
    input  logic [IADDR_W-1:0]        cfg_int_addr,
    input  logic [WAIT_W-1:0]         cfg_wait,
    output logic [PAGE_W+EADDR_W-1:0] ext_addr,
    output logic                      ext_rd,
    output logic                      ext_wr,
    output logic [7:0]                ext_wdata,
    input  logic [7:0]                ext_rdata,
    output logic [IADDR_W-1:0]        int_addr,
    output logic                      int_re,
    input  logic [23:0]               int_rdata,
    output logic                      int_we,
    output logic [23:0]               int_wdata,
    output logic                      busy,
    output logic                      irq,
    input  logic                      irq_clr
);
    state_e               state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 dir_q;
    fmt_e                 fmt_q;
    logic [PAGE_W-1:0]    page_q;
    logic [EADDR_W-1:0]   eaddr_q;
    logic [IADDR_W-1:0]   iaddr_q;
    logic [WAIT_W-1:0]    wait_q;
    logic [1:0]           bidx_q;
    logic                 irq_q;

    logic in_byte, byte_done, word_end, last_word;

    assign in_byte   = (state_q == ST_BYTE);
    assign word_end  = byte_done && (bidx_q == final_idx(fmt_q));
    assign last_word = (cnt_q == CNT_W'(1));

    bdp_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (in_byte),
        .limit (wait_q),
        .done  (byte_done)
    );

    bdp_assembler u_asm (
        .clk      (clk),
        .rst      (rst),
        .shift_en (byte_done && !dir_q),
        .byte_in  (ext_rdata),
        .fmt      (fmt_q),
        .word_out (int_wdata)
    );

    bdp_splitter u_split (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_LOAD),
        .word_in  (int_rdata),
        .fmt      (fmt_q),
        .shift_en (byte_done && dir_q),
        .byte_out (ext_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
            fmt_q   <= FMT_W24;
            page_q  <= '0;
            eaddr_q <= '0;
            iaddr_q <= '0;
            wait_q  <= '0;
            bidx_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (irq_clr) irq_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (cfg_count == '0) begin
                            irq_q <= 1'b1;
                        end else begin
                            cnt_q   <= cfg_count;
                            dir_q   <= cfg_dir;
                            fmt_q   <= fmt_e'(cfg_fmt);
                            page_q  <= cfg_page;
                            eaddr_q <= cfg_ext_addr;
                            iaddr_q <= cfg_int_addr;
                            wait_q  <= cfg_wait;
                            bidx_q  <= '0;
                            state_q <= cfg_dir ? ST_FETCH : ST_BYTE;
                        end
                    end
                end
                ST_FETCH: state_q <= ST_LOAD;
                ST_LOAD:  state_q <= ST_BYTE;
                ST_BYTE: begin
                    if (byte_done) begin
                        eaddr_q <= eaddr_q + 1'b1;
                        bidx_q  <= word_end ? 2'd0 : bidx_q + 2'd1;
                        if (word_end) begin
                            if (!dir_q) begin
                                state_q <= ST_STORE;
                            end else begin
                                cnt_q   <= cnt_q - 1'b1;
                                iaddr_q <= iaddr_q + 1'b1;
                                if (last_word) begin
                                    state_q <= ST_IDLE;
                                    irq_q   <= 1'b1;
                                end else begin
                                    state_q <= ST_FETCH;
                                end
                            end
                        end
                    end
                end
                ST_STORE: begin
                    cnt_q   <= cnt_q - 1'b1;
                    iaddr_q <= iaddr_q + 1'b1;
                    if (last_word) begin
                        state_q <= ST_IDLE;
                        irq_q   <= 1'b1;
                    end else begin
                        state_q <= ST_BYTE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ext_addr = {page_q, eaddr_q};
    assign ext_rd   = in_byte && !dir_q;
    assign ext_wr   = in_byte && dir_q;
    assign int_addr = iaddr_q;
    assign int_re   = (state_q == ST_FETCH);
    assign int_we   = (state_q == ST_STORE);
    assign busy     = (state_q != ST_IDLE);
    assign irq      = irq_q;
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] cfg_count,
    input logic             busy,
    input logic             irq,
    input logic             irq_clr,
    input logic             ext_rd,
    input logic             ext_wr,
    input logic             int_re,
    input logic             int_we,
    input logic [23:0]      int_wdata,
    input logic [1:0]       fmt_q
);
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !(ext_rd && ext_wr));

    p_zero_fill_w16_r2: assert property (@(posedge clk) disable iff (rst)
        (int_we && fmt_q == 2'b01) |-> (int_wdata[23:16] == 8'h00));

    p_zero_fill_hi8_r3: assert property (@(posedge clk) disable iff (rst)
        (int_we && fmt_q == 2'b10) |-> (int_wdata[23:16] == 8'h00 && int_wdata[7:0] == 8'h00));

    p_zero_fill_lo8_r4: assert property (@(posedge clk) disable iff (rst)
        (int_we && fmt_q == 2'b11) |-> (int_wdata[23:8] == 16'h0000));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(ext_rd || ext_wr || int_re || int_we));

    p_busy_on_start_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && cfg_count != '0) |=> busy);

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    p_irq_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !busy);

    p_zero_count_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && cfg_count == '0) |=> (!busy && irq));
endmodule

bind bytedma_packer bdp_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_count (cfg_count),
    .busy      (busy),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr),
    .int_re    (int_re),
    .int_we    (int_we),
    .int_wdata (int_wdata),
    .fmt_q     (fmt_q)
);

// File: tb/sim_bytedma_packer.sv
`timescale 1ns/1ps
module sim_bytedma_packer;
    localparam int CNT_W = 14, IADDR_W = 14, EADDR_W = 14, PAGE_W = 8, WAIT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                      start = 0;
    logic [CNT_W-1:0]          cfg_count = '0;
    logic                      cfg_dir = 0;
    logic [1:0]                cfg_fmt = '0;
    logic [PAGE_W-1:0]         cfg_page = '0;
    logic [EADDR_W-1:0]        cfg_ext_addr = '0;
    logic [IADDR_W-1:0]        cfg_int_addr = '0;
    logic [WAIT_W-1:0]         cfg_wait = '0;
    logic [PAGE_W+EADDR_W-1:0] ext_addr;
    logic                      ext_rd, ext_wr;
    logic [7:0]                ext_wdata, ext_rdata;
    logic [IADDR_W-1:0]        int_addr;
    logic                      int_re, int_we;
    logic [23:0]               int_rdata, int_wdata;
    logic                      busy, irq;
    logic                      irq_clr = 0;

    bytedma_packer #(.CNT_W(CNT_W), .IADDR_W(IADDR_W), .EADDR_W(EADDR_W),
                     .PAGE_W(PAGE_W), .WAIT_W(WAIT_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .cfg_count(cfg_count), .cfg_dir(cfg_dir),
        .cfg_fmt(cfg_fmt), .cfg_page(cfg_page), .cfg_ext_addr(cfg_ext_addr),
        .cfg_int_addr(cfg_int_addr), .cfg_wait(cfg_wait), .ext_addr(ext_addr),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .int_addr(int_addr), .int_re(int_re), .int_rdata(int_rdata), .int_we(int_we),
        .int_wdata(int_wdata), .busy(busy), .irq(irq), .irq_clr(irq_clr));

    // memory models
    logic [7:0]  bmem [0:255];
    logic [23:0] imem [0:63];
    assign ext_rdata = bmem[ext_addr[7:0]];

    int strobe_cyc = 0, byte_cnt = 0, re_cnt = 0, we_cnt = 0, bad_page = 0;
    logic [PAGE_W-1:0] exp_page = '0;
    logic prev_strb = 0;
    logic [PAGE_W+EADDR_W-1:0] prev_addr = '0;

    always @(posedge clk) begin
        if (ext_wr) bmem[ext_addr[7:0]] <= ext_wdata;
        if (int_we) imem[int_addr[5:0]] <= int_wdata;
        if (int_re) int_rdata <= imem[int_addr[5:0]];
        if (ext_rd || ext_wr) begin
            strobe_cyc <= strobe_cyc + 1;
            if (!prev_strb || prev_addr != ext_addr) byte_cnt <= byte_cnt + 1;
            if (ext_addr[PAGE_W+EADDR_W-1:EADDR_W] != exp_page) bad_page <= bad_page + 1;
        end
        if (int_re) re_cnt <= re_cnt + 1;
        if (int_we) we_cnt <= we_cnt + 1;
        prev_strb <= ext_rd || ext_wr;
        prev_addr <= ext_addr;
    end

    int n_checks = 0, n_errors = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] f);
        return (f == 2'b00) ? 3 : (f == 2'b01) ? 2 : 1;
    endfunction

    function automatic string fmt_req(input logic [1:0] f);
        case (f)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic clear_mon();
        strobe_cyc = 0; byte_cnt = 0; re_cnt = 0; we_cnt = 0; bad_page = 0;
    endtask

    task automatic wait_irq();
        int i;
        for (i = 0; i < 5000 && !irq; i++) @(negedge clk);
        check(irq == 1'b1, "R8 irq after transfer", {31'b0, irq}, 1);
    endtask

    task automatic pulse_start(input bit dir, input logic [1:0] f, input int wt, input int cnt,
                               input int pg, input int ea, input int ia);
        cfg_dir = dir; cfg_fmt = f; cfg_wait = WAIT_W'(wt); cfg_count = CNT_W'(cnt);
        cfg_page = PAGE_W'(pg); cfg_ext_addr = EADDR_W'(ea); cfg_int_addr = IADDR_W'(ia);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic clear_irq();
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        check(irq == 1'b0, "R8 irq cleared", {31'b0, irq}, 0);
    endtask

    // byte memory -> internal memory
    task automatic t_read(input logic [1:0] f, input int wt, input int cnt,
                          input int pg, input int ea, input int ia);
        logic [23:0] exp;
        int n = nbytes(f);
        imem[(ia + cnt) & 63] = 24'h5A5A5A;
        exp_page = PAGE_W'(pg);
        clear_mon();
        pulse_start(1'b0, f, wt, cnt, pg, ea, ia);
        check(busy == 1'b1, "R8 busy after start", {31'b0, busy}, 1);
        wait_irq();
        check(busy == 1'b0, "R8 busy low at irq", {31'b0, busy}, 0);
        for (int k = 0; k < cnt; k++) begin
            logic [7:0] b0, b1, b2;
            b0 = bmem[(ea + k*n) & 255];
            b1 = bmem[(ea + k*n + 1) & 255];
            b2 = bmem[(ea + k*n + 2) & 255];
            case (f)
                2'b00: exp = {b0, b1, b2};
                2'b01: exp = {8'h00, b0, b1};
                2'b10: exp = {8'h00, b0, 8'h00};
                default: exp = {16'h0000, b0};
            endcase
            check(imem[(ia + k) & 63] === exp, fmt_req(f), {8'h0, imem[(ia + k) & 63]}, {8'h0, exp});
        end
        check(imem[(ia + cnt) & 63] === 24'h5A5A5A, "R9 word past end untouched",
              {8'h0, imem[(ia + cnt) & 63]}, 32'h5A5A5A);
        check(we_cnt == cnt, "R9 word writes", we_cnt, cnt);
        check(byte_cnt == cnt*n, "R6 byte accesses", byte_cnt, cnt*n);
        check(strobe_cyc == cnt*n*(wt+1), "R5 strobe cycles", strobe_cyc, cnt*n*(wt+1));
        check(bad_page == 0, "R6 page bits", bad_page, 0);
        clear_irq();
    endtask

    // internal memory -> byte memory
    task automatic t_write(input logic [1:0] f, input int wt, input int cnt,
                           input int pg, input int ea, input int ia);
        logic [7:0] eb [0:2];
        int n = nbytes(f);
        bmem[(ea + cnt*n) & 255] = 8'hC3;
        exp_page = PAGE_W'(pg);
        clear_mon();
        pulse_start(1'b1, f, wt, cnt, pg, ea, ia);
        check(busy == 1'b1, "R8 busy after start", {31'b0, busy}, 1);
        wait_irq();
        for (int k = 0; k < cnt; k++) begin
            logic [23:0] w;
            w = imem[(ia + k) & 63];
            case (f)
                2'b00: begin eb[0] = w[23:16]; eb[1] = w[15:8]; eb[2] = w[7:0]; end
                2'b01: begin eb[0] = w[15:8]; eb[1] = w[7:0]; eb[2] = 8'h00; end
                2'b10: begin eb[0] = w[15:8]; eb[1] = 8'h00; eb[2] = 8'h00; end
                default: begin eb[0] = w[7:0]; eb[1] = 8'h00; eb[2] = 8'h00; end
            endcase
            for (int j = 0; j < n; j++)
                check(bmem[(ea + k*n + j) & 255] === eb[j], "R7 byte order/content",
                      {24'h0, bmem[(ea + k*n + j) & 255]}, {24'h0, eb[j]});
        end
        check(bmem[(ea + cnt*n) & 255] === 8'hC3, "R7 byte past end untouched",
              {24'h0, bmem[(ea + cnt*n) & 255]}, 32'hC3);
        check(re_cnt == cnt, "R7 one read per word", re_cnt, cnt);
        check(strobe_cyc == cnt*n*(wt+1), "R5 write strobe cycles", strobe_cyc, cnt*n*(wt+1));
        check(bad_page == 0, "R6 page bits on write", bad_page, 0);
        clear_irq();
    endtask

    task automatic t_reset();
        check(busy == 0 && irq == 0, "R8 reset busy/irq", {30'b0, busy, irq}, 0);
        check(!ext_rd && !ext_wr && !int_re && !int_we, "R8 reset strobes quiet",
              {28'b0, ext_rd, ext_wr, int_re, int_we}, 0);
    endtask

    task automatic t_zero_count();
        clear_mon();
        pulse_start(1'b0, 2'b00, 0, 0, 0, 0, 0);
        check(busy == 1'b0, "R10 busy stays low", {31'b0, busy}, 0);
        check(irq == 1'b1, "R10 irq next cycle", {31'b0, irq}, 1);
        repeat (3) @(negedge clk);
        check(strobe_cyc == 0 && we_cnt == 0 && re_cnt == 0, "R10 no accesses",
              strobe_cyc + we_cnt + re_cnt, 0);
        clear_irq();
    endtask

    task automatic t_start_while_busy();
        exp_page = 8'h11;
        clear_mon();
        imem[40] = 24'h5A5A5A; imem[41] = 24'h5A5A5A; imem[42] = 24'h5A5A5A;
        pulse_start(1'b0, 2'b01, 1, 2, 8'h11, 100, 40);
        repeat (2) @(negedge clk);
        pulse_start(1'b0, 2'b11, 0, 5, 8'h22, 0, 0);
        wait_irq();
        check(imem[40] === {8'h00, bmem[100], bmem[101]}, "R9 first word kept config",
              {8'h0, imem[40]}, {16'h0, bmem[100], bmem[101]});
        check(imem[41] === {8'h00, bmem[102], bmem[103]}, "R9 second word kept config",
              {8'h0, imem[41]}, {16'h0, bmem[102], bmem[103]});
        check(imem[42] === 24'h5A5A5A, "R9 ignored start adds no word", {8'h0, imem[42]}, 32'h5A5A5A);
        check(bad_page == 0 && we_cnt == 2, "R9 page and count unchanged", bad_page * 100 + we_cnt, 2);
        repeat (3) @(negedge clk);
        check(irq == 1'b1, "R8 irq sticky without clear", {31'b0, irq}, 1);
        clear_irq();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 37 + 11);
        for (int i = 0; i < 64; i++) imem[i] = 24'(i * 24'h13579B + 24'h2468AC);
        int_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_read(2'b00, 0, 3, 8'h05, 16, 2);
        t_read(2'b01, 2, 4, 8'hA0, 40, 10);
        t_read(2'b10, 7, 2, 8'h01, 60, 20);
        t_read(2'b11, 1, 3, 8'hFF, 70, 25);
        t_write(2'b00, 3, 2, 8'h07, 128, 2);
        t_write(2'b01, 0, 3, 8'h08, 150, 10);
        t_write(2'b10, 2, 2, 8'h09, 170, 20);
        t_write(2'b11, 0, 3, 8'h0A, 180, 25);
        t_zero_count();
        t_start_while_busy();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule